// File: doc/BRIEF.md
# LCD Pixel Capture to SRAM

This block grabs a single frame from a parallel RGB panel bus and stores it in an external asynchronous SRAM. The panel offers only a pixel clock, a frame sync and an 18-bit colour word (three 6-bit channels). It has no line sync. The block therefore builds its own pixel position. A 263-count horizontal counter is reloaded on every detected frame-sync edge, and a line counter steps each time that horizontal counter wraps.

Each sampled pixel goes into one 32-bit SRAM word. The address is the line count placed above the horizontal count. This wastes the top part of each 512-word line, but it keeps the address logic to plain wiring. The reload value for the horizontal counter is an input, so the visible pixels can be moved into whichever half of each line the readout software expects.

Software pulses an arm input. The block then waits for the next frame-sync edge, writes exactly one frame, and raises a done flag. A build-time parameter selects whether the panel data is taken on the rising or the falling pixel-clock edge, because the two screens of a dual-panel device latch on opposite edges.

Top module: `lcd_capture`

## Requirements
- R1: While reset is asserted and directly after it, sramWe and done are both 0.
- R2: While the block is not armed, frame-sync edges cause no SRAM writes.
- R3: After armTrig, capture starts at the first rising edge of vsyncIn and never at a falling edge. vsyncIn passes through two synchroniser flops. The first stored pixel is therefore the one sampled on the third sampling edge after vsyncIn is first seen high, and it lands at horizontal position hOffset on line 0.
- R4: The horizontal position counts hOffset, hOffset+1, ... up to 262 and then wraps to 0. The line count increments on that wrap. sramAddr = {line[7:0], horizontal[8:0]}, so bits 8:0 carry the horizontal position and bits 16:9 carry the line.
- R5: sramData = {14'b0, rgbIn}, with the pixel in bits 17:0 and bits 31:18 zero.
- R6: A frame of F pixel clocks between two rising vsyncIn edges produces exactly F writes. Each write is a one-clock sramWe strobe, and address and data are stable while it is high.
- R7: done rises on the clock after the final write strobe and stays high. Later frame-sync edges cause no writes until the block is armed again.
- R8: armTrig pulses during a capture have no effect on the frame being written.
- R9: Arming again from the done state clears done. The next frame is captured with the current hOffset as its starting horizontal position.
- R10: With SAMPLE_FALL=1 the block samples on the falling pixel-clock edge and stores the same address and data sequence as the rising-edge build for the same input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pixClk | input | 1 | Panel pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vsyncIn | input | 1 | Panel frame sync, asynchronous |
| rgbIn | input | 18 | Panel colour word, 6 bits per channel |
| armTrig | input | 1 | Single-cycle pulse that arms a one-frame capture |
| hOffset | input | 9 | Horizontal counter reload value on frame sync (0 to 262) |
| sramAddr | output | 17 | SRAM word address {line, horizontal} |
| sramData | output | 32 | SRAM write data, pixel zero-extended |
| sramWe | output | 1 | Active-high SRAM write strobe, one clock per pixel |
| done | output | 1 | Frame captured |

## Verification
A wrong horizontal or line count shows in sramAddr on the first affected write. A bad reload appears on the very first word of a frame, and a bad wrap appears within 263 clocks. A stuck or mistimed control state shows in the number of write strobes between two frame-sync edges, or in done being early, late or missing. Every write of two whole frames is compared against positions and pixel values computed from the bench's own cycle count. One of the two frames has a reload value close to the wrap point. The falling-edge build's full write stream is compared word for word against the rising-edge build.

// File: rtl/lcdcap_pkg.sv
package lcdcap_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPos;  // frame-sync edge seen: reload position counters
    logic wrStb;    // store current pixel this clock
  } capCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAP   = 2'd2,
    ST_DONE  = 2'd3
  } capState_t;

endpackage

// File: rtl/lcdcap_ctrl.sv
module lcdcap_ctrl
  import lcdcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit VS_RISE     = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    vsyncIn,
  input  logic    armTrig,
  output capCtl_t ctl,
  output logic    done
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] vsPipe;
  logic              vsEdge;
  capState_t         state;
  capState_t         stateNext;
  logic              doneReg;

  // synchroniser plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vsPipe <= '0;
    else       vsPipe <= {vsPipe[PIPE_W-2:0], vsyncIn};
  end

  generate
    if (VS_RISE) begin : g_rise
      assign vsEdge = vsPipe[PIPE_W-2] & ~vsPipe[PIPE_W-1];
    end else begin : g_fall
      assign vsEdge = ~vsPipe[PIPE_W-2] & vsPipe[PIPE_W-1];
    end
  endgenerate

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (armTrig) stateNext = ST_ARMED;
      ST_ARMED: if (vsEdge)  stateNext = ST_CAP;
      ST_CAP:   if (vsEdge)  stateNext = ST_DONE;
      ST_DONE:  if (armTrig) stateNext = ST_ARMED;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneReg <= 1'b0;
    end else begin
      state   <= stateNext;
      doneReg <= (state == ST_DONE);
    end
  end

  assign ctl.loadPos = vsEdge;
  assign ctl.wrStb   = (state == ST_CAP);
  assign done        = doneReg;

endmodule

// File: rtl/lcdcap_dpath.sv
module lcdcap_dpath
  import lcdcap_pkg::*;
#(
  parameter int PIX_W  = 18,
  parameter int WORD_W = 32,
  parameter int H_W    = 9,
  parameter int V_W    = 8,
  parameter int H_LEN  = 263
) (
  input  logic               clk,
  input  logic               rstN,
  input  capCtl_t            ctl,
  input  logic [PIX_W-1:0]   rgbIn,
  input  logic [H_W-1:0]     hOffset,
  output logic [V_W+H_W-1:0] sramAddr,
  output logic [WORD_W-1:0]  sramData,
  output logic               sramWe
);

  localparam logic [H_W-1:0] H_LAST = H_W'(H_LEN - 1);
  localparam int             PAD_W  = WORD_W - PIX_W;

  logic [H_W-1:0] hCnt;
  logic [V_W-1:0] vCnt;

  // position counters; the line count steps when the horizontal wraps
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (ctl.loadPos) begin
      hCnt <= hOffset;
      vCnt <= '0;
    end else if (hCnt == H_LAST) begin
      hCnt <= '0;
      vCnt <= vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  // output registers; address and data only move on a write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sramAddr <= '0;
      sramData <= '0;
      sramWe   <= 1'b0;
    end else begin
      sramWe <= ctl.wrStb;
      if (ctl.wrStb) begin
        sramAddr <= {vCnt, hCnt};
        sramData <= {{PAD_W{1'b0}}, rgbIn};
      end
    end
  end

endmodule

// File: rtl/lcd_capture.sv
module lcd_capture
  import lcdcap_pkg::*;
#(
  parameter int PIX_W       = 18,
  parameter int WORD_W      = 32,
  parameter int H_W         = 9,
  parameter int V_W         = 8,
  parameter int H_LEN       = 263,
  parameter int SYNC_STAGES = 2,
  parameter bit VS_RISE     = 1'b1,
  parameter bit SAMPLE_FALL = 1'b0
) (
  input  logic               pixClk,
  input  logic               rstN,
  input  logic               vsyncIn,
  input  logic [PIX_W-1:0]   rgbIn,
  input  logic               armTrig,
  input  logic [H_W-1:0]     hOffset,
  output logic [V_W+H_W-1:0] sramAddr,
  output logic [WORD_W-1:0]  sramData,
  output logic               sramWe,
  output logic               done
);

  logic    sampClk;
  capCtl_t ctl;

  generate
    if (SAMPLE_FALL) begin : g_fallclk
      assign sampClk = ~pixClk;
    end else begin : g_riseclk
      assign sampClk = pixClk;
    end
  endgenerate

  lcdcap_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .VS_RISE    (VS_RISE)
  ) u_ctrl (
    .clk    (sampClk),
    .rstN   (rstN),
    .vsyncIn(vsyncIn),
    .armTrig(armTrig),
    .ctl    (ctl),
    .done   (done)
  );

  lcdcap_dpath #(
    .PIX_W (PIX_W),
    .WORD_W(WORD_W),
    .H_W   (H_W),
    .V_W   (V_W),
    .H_LEN (H_LEN)
  ) u_dpath (
    .clk     (sampClk),
    .rstN    (rstN),
    .ctl     (ctl),
    .rgbIn   (rgbIn),
    .hOffset (hOffset),
    .sramAddr(sramAddr),
    .sramData(sramData),
    .sramWe  (sramWe)
  );

endmodule

// File: rtl/lcdcap_chk.sv
module lcdcap_chk #(
  parameter int PIX_W  = 18,
  parameter int WORD_W = 32,
  parameter int H_W    = 9,
  parameter int V_W    = 8,
  parameter int H_LEN  = 263
) (
  input logic               clk,
  input logic               rstN,
  input logic               sramWe,
  input logic               done,
  input logic [V_W+H_W-1:0] sramAddr,
  input logic [WORD_W-1:0]  sramData
);

  localparam logic [H_W-1:0] H_LAST = H_W'(H_LEN - 1);

  logic [H_W-1:0] hPos;
  logic [V_W-1:0] vPos;
  assign hPos = sramAddr[H_W-1:0];
  assign vPos = sramAddr[V_W+H_W-1:H_W];

  // R4
  hbound_chk: assert property (@(posedge clk) disable iff (!rstN)
    sramWe |-> (hPos <= H_LAST));

  // R4
  hstep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sramWe && $past(sramWe)) |->
      ((hPos == H_W'($past(hPos) + 1'b1)) ||
       ((hPos == '0) && ($past(hPos) == H_LAST))));

  // R4
  vstep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sramWe && $past(sramWe) && (hPos == '0)) |->
      (vPos == V_W'($past(vPos) + 1'b1)));

  // R5
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    sramWe |-> (sramData[WORD_W-1:PIX_W] == '0));

  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !sramWe);

  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(sramWe));

endmodule

bind lcd_capture lcdcap_chk #(
  .PIX_W (PIX_W),
  .WORD_W(WORD_W),
  .H_W   (H_W),
  .V_W   (V_W),
  .H_LEN (H_LEN)
) u_chk (
  .clk     (sampClk),
  .rstN    (rstN),
  .sramWe  (sramWe),
  .done    (done),
  .sramAddr(sramAddr),
  .sramData(sramData)
);

// File: tb/sim_lcd_capture.sv
`timescale 1ns/1ps
module sim_lcd_capture;

  localparam int HL = 263;
  localparam int FA = 800;
  localparam int FB = 600;

  logic        clk = 1'b0;
  logic        rstN;
  logic        vsync;
  logic [17:0] rgb;
  logic        arm;
  logic [8:0]  hOff;

  logic [16:0] addr0, addr1;
  logic [31:0] data0, data1;
  logic        we0, we1, done0, done1;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int n0 = 0, n1 = 0;
  int a0 [0:2047];
  int d0 [0:2047];
  int a1 [0:2047];
  int d1 [0:2047];

  always #5 clk = ~clk;

  lcd_capture u0 (
    .pixClk(clk), .rstN(rstN), .vsyncIn(vsync), .rgbIn(rgb),
    .armTrig(arm), .hOffset(hOff), .sramAddr(addr0), .sramData(data0),
    .sramWe(we0), .done(done0)
  );

  lcd_capture #(.SAMPLE_FALL(1'b1)) u1 (
    .pixClk(clk), .rstN(rstN), .vsyncIn(vsync), .rgbIn(rgb),
    .armTrig(arm), .hOffset(hOff), .sramAddr(addr1), .sramData(data1),
    .sramWe(we1), .done(done1)
  );

  function automatic logic [17:0] pixOf(int c);
    return 18'((c * 2731) ^ (c << 9) ^ 5);
  endfunction

  // pixel stream: new word shortly after each rising edge
  always @(posedge clk) begin
    #2;
    cyc = cyc + 1;
    rgb = pixOf(cyc);
  end

  // write loggers, each away from its instance's active edge
  always @(negedge clk) begin
    if (rstN === 1'b1 && we0 === 1'b1 && n0 < 2048) begin
      a0[n0] = int'(addr0);
      d0[n0] = int'(data0);
      n0 = n0 + 1;
    end
  end

  always @(posedge clk) begin
    if (rstN === 1'b1 && we1 === 1'b1 && n1 < 2048) begin
      a1[n1] = int'(addr1);
      d1[n1] = int'(data1);
      n1 = n1 + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) begin
      @(posedge clk);
      #3;
    end
  endtask

  task automatic toCyc(input int t);
    do begin
      @(posedge clk);
      #3;
    end while (cyc < t);
  endtask

  task automatic pulseVs(input int len, input int gap);
    vsync = 1'b1;
    waitN(len);
    vsync = 1'b0;
    waitN(gap);
  endtask

  task automatic pulseArm();
    arm = 1'b1;
    waitN(1);
    arm = 1'b0;
  endtask

  task automatic verifyFrame(input int base, input int cVs, input int pre, input int f, input string tag);
    for (int n = 0; n < f; n++) begin
      int p;
      int expA;
      p    = pre + n;
      expA = ((p / HL) % 256) * 512 + (p % HL);
      chk(a0[base + n] == expA, {tag, " R4 address"}, a0[base + n], expA);
      chk(d0[base + n] == int'(pixOf(cVs + 3 + n)), "R5 data",
          d0[base + n], int'(pixOf(cVs + 3 + n)));
    end
    chk(a0[base] == pre, {tag, " R3 first address"}, a0[base], pre);
  endtask

  initial begin
    #2_000_000;
    bad   = bad + 1;
    total = total + 1;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    int cVs;
    int keep;
    rstN  = 1'b0;
    vsync = 1'b0;
    arm   = 1'b0;
    hOff  = 9'd0;
    rgb   = '0;
    waitN(3);
    // R1 during reset
    chk(we0 == 1'b0 && done0 == 1'b0, "R1 in reset", {we0, done0}, 0);
    rstN = 1'b1;
    waitN(4);
    chk(we0 == 1'b0 && done0 == 1'b0, "R1 after reset", {we0, done0}, 0);
    chk(we1 == 1'b0 && done1 == 1'b0, "R1 fall build", {we1, done1}, 0);

    // R2: frame syncs while idle
    pulseVs(4, 30);
    pulseVs(4, 30);
    chk(n0 == 0, "R2 idle writes", n0, 0);

    // R3: armed with sync high, its falling edge must not start capture
    vsync = 1'b1;
    waitN(2);
    pulseArm();
    waitN(10);
    vsync = 1'b0;
    waitN(20);
    chk(n0 == 0, "R3 falling edge ignored", n0, 0);

    // frame A, hOffset 0
    base  = n0;
    vsync = 1'b1;
    cVs   = cyc;
    waitN(4);
    vsync = 1'b0;
    toCyc(cVs + 300);
    pulseArm();  // R8 arm during capture
    chk(done0 == 1'b0, "R7 done low mid-frame", done0, 0);
    toCyc(cVs + FA);
    vsync = 1'b1;
    waitN(4);
    vsync = 1'b0;
    waitN(4);
    chk(n0 - base == FA, "R6 frame A write count", n0 - base, FA);
    chk(n0 - base == FA, "R8 count after mid-frame arm", n0 - base, FA);
    chk(done0 == 1'b1, "R7 done after frame A", done0, 1);
    verifyFrame(base, cVs, 0, FA, "frameA");

    // R7: no further writes on later syncs
    keep = n0;
    pulseVs(4, 40);
    pulseVs(4, 40);
    chk(n0 == keep, "R7 writes after done", n0, keep);
    chk(done0 == 1'b1, "R7 done held", done0, 1);

    // R9: re-arm with a preload near the wrap point
    hOff = 9'd250;
    pulseArm();
    waitN(3);
    chk(done0 == 1'b0, "R9 done cleared", done0, 0);
    base  = n0;
    vsync = 1'b1;
    cVs   = cyc;
    waitN(4);
    vsync = 1'b0;
    toCyc(cVs + FB);
    vsync = 1'b1;
    waitN(4);
    vsync = 1'b0;
    waitN(4);
    chk(n0 - base == FB, "R9 frame B write count", n0 - base, FB);
    chk(done0 == 1'b1, "R9 done after frame B", done0, 1);
    verifyFrame(base, cVs, 250, FB, "frameB R9");

    // R10: falling-edge build stores the same stream
    waitN(2);
    chk(n1 == n0, "R10 write count", n1, n0);
    for (int i = 0; i < n0 && i < n1; i++) begin
      chk(a1[i] == a0[i], "R10 address", a1[i], a0[i]);
      chk(d1[i] == d0[i], "R10 data", d1[i], d0[i]);
    end
    chk(done1 == 1'b1, "R10 done", done1, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule